// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns three external pins into interrupt requests. Two of the pins are sampled by the system clock, and each has its own 2-bit sense mode: low level, any change, falling edge or rising edge. The third pin is caught asynchronously on the edge chosen by a 1-bit polarity select, so no clock has to be running at the moment the edge occurs. Each edge that is detected sets a sticky flag. A flag stays set until software writes a one to it, or until the interrupt controller returns an acknowledge pulse for that line.

Software uses a small register port with four byte-wide locations. Through it, software sets the sense modes, the polarity, the per-line masks and the global enable, and it reads and clears the flags. The block drives one request line per pin and a combined IRQ, which is the OR of the per-line requests. In low-level mode a synchronous line sets no flag. Its request follows the synchronized pin directly, so the pin must stay low until the request has been serviced.

Top module: `ext_irq_sense`

## Requirements
- R1: Address 0 holds the sense codes: bits 1:0 for line 0 and bits 3:2 for line 1. The codes are 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. Address 1 bit 6 is the polarity of line 2. Address 2 holds the mask bits for lines 0..2 in bits 2:0 and the global enable in bit 7. All of these read back as written, and unused bits read as zero.
- R2: `req[i]` is high only when the global enable and mask bit i are both set. A flag that is set while either bit is clear shows at address 3 but raises no request. `irq` is the OR of `req`.
- R3: Each synchronous pin passes through two sampling flops. Take a pin change made between clock edges. Its flag at address 3 (bit i for line i) is still clear after the second rising clock edge. It is set after the third rising clock edge. In falling mode only falling transitions set the flag, and in rising mode only rising transitions set it.
- R4: In any-change mode, both rising and falling pin transitions set the flag.
- R5: In low-level mode the request is high while the synchronized pin is low. It appears after the second rising clock edge following the pin falling, and it drops after the second edge following the pin rising. The flag is never set in this mode.
- R6: Writing address 3 clears every flag whose data bit is one. Flags whose data bit is zero are left unchanged.
- R7: An `ack[i]` pulse clears flag i on the next clock edge. If a new edge for line i is detected in the same cycle as the acknowledge, the flag stays set.
- R8: Line 2 is captured asynchronously. Polarity 0 selects falling edges and polarity 1 selects rising edges, and edges of the other direction are ignored. A pulse narrower than a clock period is still captured. The captured edge sets flag bit 2 within four clock edges.
- R9: Changing the polarity while the pin is at the level that makes the new polarity's edge (for example, switching to rising while the pin is high) sets flag bit 2. The masked sequence is: disable the line, change the polarity, clear the flag, then re-enable. This sequence leaves no request.
- R10: After reset, all four addresses read zero, and `req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_sync | input | NSYNC | Pins that are sampled by the clock |
| pin_async | input | 1 | Pin that is edge-captured asynchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| ack | input | NSYNC+1 | Per-line flag clear from the interrupt controller |
| req | output | NSYNC+1 | Per-line gated request |
| irq | output | 1 | OR of all requests |

## Verification
The bench builds the block with its default parameters: two synchronous lines and a two-stage synchronizer. This configuration makes the exact three-edge flag latency and the two-edge level latency observable cycle by cycle, and puts the asynchronous line at flag bit 2. With the clock-domain chain this short, the bench can place an acknowledge in exactly the cycle a new edge is detected. It can also show that a sub-cycle pulse on the asynchronous pin is still captured, and that a polarity change produces a false flag.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int NSYNC       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 2,
  parameter int DW          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSYNC-1:0]  pin_sync,
  input  logic              pin_async,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NSYNC:0]    ack,
  output logic [NSYNC:0]    req,
  output logic              irq
);
  localparam int NLINES  = NSYNC + 1;
  localparam int AIDX    = NSYNC;
  localparam int SW      = 2 * NSYNC;
  localparam int POL_BIT = 6;
  localparam int GIE_BIT = 7;
  localparam logic [AW-1:0] A_SENSE = AW'(0);
  localparam logic [AW-1:0] A_POL   = AW'(1);
  localparam logic [AW-1:0] A_MASK  = AW'(2);
  localparam logic [AW-1:0] A_FLAG  = AW'(3);

  logic [SW-1:0]     sense_q;
  logic              pol_q;
  logic [NLINES-1:0] mask_q;
  logic              gie_q;
  logic [NLINES-1:0] flag_q, set_ev, clr_ev, src;
  logic [NSYNC-1:0]  lvl_s, lvl_p, is_level;

  wire wr_sense = reg_we && (reg_addr == A_SENSE);
  wire wr_pol   = reg_we && (reg_addr == A_POL);
  wire wr_mask  = reg_we && (reg_addr == A_MASK);
  wire wr_flag  = reg_we && (reg_addr == A_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      pol_q   <= 1'b0;
      mask_q  <= '0;
      gie_q   <= 1'b0;
    end else begin
      if (wr_sense) sense_q <= reg_wdata[SW-1:0];
      if (wr_pol)   pol_q   <= reg_wdata[POL_BIT];
      if (wr_mask) begin
        mask_q <= reg_wdata[NLINES-1:0];
        gie_q  <= reg_wdata[GIE_BIT];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SENSE: reg_rdata[SW-1:0] = sense_q;
      A_POL:   reg_rdata[POL_BIT] = pol_q;
      A_MASK:  begin
        reg_rdata[NLINES-1:0] = mask_q;
        reg_rdata[GIE_BIT]    = gie_q;
      end
      default: reg_rdata[NLINES-1:0] = flag_q;
    endcase
  end

  for (genvar i = 0; i < NSYNC; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    logic [1:0] mode;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain    <= '1;
        lvl_p[i] <= 1'b1;
      end else begin
        chain    <= {chain[SYNC_STAGES-2:0], pin_sync[i]};
        lvl_p[i] <= chain[SYNC_STAGES-1];
      end
    end
    assign lvl_s[i]    = chain[SYNC_STAGES-1];
    assign mode        = sense_q[2*i +: 2];
    assign is_level[i] = (mode == 2'b00);
    always_comb begin
      case (mode)
        2'b01:   set_ev[i] = lvl_s[i] ^ lvl_p[i];
        2'b10:   set_ev[i] = lvl_p[i] & ~lvl_s[i];
        2'b11:   set_ev[i] = lvl_s[i] & ~lvl_p[i];
        default: set_ev[i] = 1'b0;
      endcase
    end
    assign src[i] = is_level[i] ? ~lvl_s[i] : flag_q[i];

    a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && lvl_s[i] && !lvl_p[i]) |=> flag_q[i]);
    a_r3_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !lvl_s[i] && lvl_p[i]) |=> flag_q[i]);
    a_r5_level_noflag: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !flag_q[i]) |=> !flag_q[i]);
  end

  logic cap_clk, cap_tog;
  logic [SYNC_STAGES:0] tog_chain;
  assign cap_clk = ~(pin_async ^ pol_q);

  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) cap_tog <= 1'b0;
    else        cap_tog <= ~cap_tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_chain <= '0;
    else        tog_chain <= {tog_chain[SYNC_STAGES-1:0], cap_tog};
  end

  assign set_ev[AIDX] = tog_chain[SYNC_STAGES] ^ tog_chain[SYNC_STAGES-1];
  assign src[AIDX]    = flag_q[AIDX];

  assign clr_ev = ack | (wr_flag ? reg_wdata[NLINES-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_ev) | set_ev;
  end

  assign req = src & mask_q & {NLINES{gie_q}};
  assign irq = |req;

  for (genvar j = 0; j < NLINES; j++) begin : g_chk
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[j] && !set_ev[j]) |=> !flag_q[j]);
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[j] && set_ev[j]) |=> flag_q[j]);
    a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[j] && !ack[j] && !(wr_flag && reg_wdata[j])) |=> flag_q[j]);
  end

  a_r2_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie_q);
  a_r2_req_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (req & ~mask_q) == '0);
endmodule

// File: tb/ext_irq_sense_bench.sv
`timescale 1ns/1ps
module ext_irq_sense_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_sync = 2'b11;
  logic       pin_async = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [2:0] ack = 3'b000;
  logic [2:0] req;
  logic       irq;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_sense u_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .pin_async(pin_async),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack(ack), .req(req), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [7:0] exp);
    reg_addr = a;
    #0.1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic t_reset;
    rd("R10 sense", 2'd0, 8'h00);
    rd("R10 pol", 2'd1, 8'h00);
    rd("R10 mask", 2'd2, 8'h00);
    rd("R10 flag", 2'd3, 8'h00);
    check("R10 req", req, 3'b000);
    check("R10 irq", irq, 1'b0);
  endtask

  task automatic t_regs;
    wr(2'd0, 8'hFE); rd("R1 sense", 2'd0, 8'h0E);
    wr(2'd1, 8'hFF); rd("R1 pol", 2'd1, 8'h40);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF); rd("R1 mask", 2'd2, 8'h87);
    wr(2'd2, 8'h00);
    tick(4);
    wr(2'd3, 8'h07);
    rd("R1 flags cleared", 2'd3, 8'h00);
  endtask

  task automatic t_gating;
    wr(2'd0, 8'h02);
    pin_sync[0] = 1'b0; tick(4);
    rd("R2 flag set while masked", 2'd3, 8'h01);
    check("R2 no enables", req, 3'b000);
    wr(2'd2, 8'h01); check("R2 mask only", req, 3'b000);
    wr(2'd2, 8'h80); check("R2 gie only", irq, 1'b0);
    wr(2'd2, 8'h81); check("R2 both req", req, 3'b001);
    check("R2 irq", irq, 1'b1);
    pin_sync[0] = 1'b1; tick(4);
    rd("R3 rising ignored in falling mode", 2'd3, 8'h01);
    wr(2'd3, 8'h01);
    check("R2 req after clear", req, 3'b000);
  endtask

  task automatic t_latency;
    wr(2'd2, 8'h87);
    wr(2'd0, 8'h0E);
    pin_sync[1] = 1'b0; tick(4);
    rd("R3 falling ignored in rising mode", 2'd3, 8'h00);
    pin_sync[1] = 1'b1; tick(2);
    rd("R3 not yet after two edges", 2'd3, 8'h00);
    tick(1);
    rd("R3 set after third edge", 2'd3, 8'h02);
    check("R3 req", req, 3'b010);
    wr(2'd3, 8'h02);
  endtask

  task automatic t_change;
    wr(2'd0, 8'h04);
    pin_sync[1] = 1'b0; tick(4);
    rd("R4 falling sets", 2'd3, 8'h02);
    wr(2'd3, 8'h02);
    pin_sync[1] = 1'b1; tick(4);
    rd("R4 rising sets", 2'd3, 8'h02);
    wr(2'd3, 8'h02);
  endtask

  task automatic t_level;
    pin_sync[0] = 1'b0; tick(1);
    check("R5 level not yet", req[0], 1'b0);
    tick(1);
    check("R5 level req", req[0], 1'b1);
    rd("R5 no flag", 2'd3, 8'h00);
    pin_sync[0] = 1'b1; tick(2);
    check("R5 level release", req[0], 1'b0);
  endtask

  task automatic t_w1c;
    pin_sync[1] = 1'b0; tick(4);
    wr(2'd3, 8'h00); rd("R6 zero write", 2'd3, 8'h02);
    wr(2'd3, 8'hFD); rd("R6 other ones", 2'd3, 8'h02);
    wr(2'd3, 8'h02); rd("R6 one clears", 2'd3, 8'h00);
  endtask

  task automatic t_ack;
    pin_sync[1] = 1'b1; tick(4);
    ack = 3'b010; tick(1); ack = 3'b000;
    rd("R7 ack clears", 2'd3, 8'h00);
    check("R7 req after ack", req[1], 1'b0);
    pin_sync[1] = 1'b0; tick(4);
    rd("R7 flag again", 2'd3, 8'h02);
    pin_sync[1] = 1'b1; tick(2);
    ack = 3'b010; tick(1); ack = 3'b000;
    rd("R7 edge wins over ack", 2'd3, 8'h02);
    wr(2'd3, 8'h02);
  endtask

  task automatic t_async;
    pin_async = 1'b0; tick(4);
    rd("R8 falling captured", 2'd3, 8'h04);
    check("R8 req", req, 3'b100);
    wr(2'd3, 8'h04);
    pin_async = 1'b1; tick(4);
    rd("R8 rising ignored", 2'd3, 8'h00);
    wr(2'd2, 8'h83);
    wr(2'd1, 8'h40); tick(4);
    rd("R9 spurious flag", 2'd3, 8'h04);
    check("R9 masked no req", req, 3'b000);
    wr(2'd3, 8'h04);
    wr(2'd2, 8'h87);
    check("R9 no req after sequence", irq, 1'b0);
    pin_async = 1'b0; tick(4);
    rd("R8 falling ignored", 2'd3, 8'h00);
    pin_async = 1'b1; tick(4);
    rd("R8 rising captured", 2'd3, 8'h04);
    wr(2'd3, 8'h04);
    pin_async = 1'b0; #1.0; pin_async = 1'b1;
    tick(4);
    rd("R8 narrow pulse", 2'd3, 8'h04);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset;
    t_regs;
    t_gating;
    t_latency;
    t_change;
    t_level;
    t_w1c;
    t_ack;
    t_async;
    if (!done) begin
      done = 1'b1;
      summary;
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary;
      $finish;
    end
  end
endmodule